// File: doc/BRIEF.md
# Serial EEPROM Word-Access Master

This block drives a byte-addressed serial EEPROM over a four-wire SPI link and offers the host a 16-bit word view of it. The host issues one request at a time: a direction, a starting word offset and a word count. Write words are pulled from the host one per `wr_take` pulse. Read words are pushed back one per `rd_valid` pulse. A single `done` pulse ends every request, and `err` carries the outcome.

Before each command the block polls the device status until its busy bit clears, giving up after a bounded number of attempts. Reads are issued as one command followed by a continuous stream, and the device's own address counter advances through the array. Writes are preceded by a write-enable command. They are cut into separate bursts wherever the byte address reaches a page boundary, and each new burst repeats the status polling and the write-enable. The first byte on the wire is the low byte of each word. For parts with 8 address bits, byte address bit 8 travels inside the opcode.

Top module: `sprom_word_master`

## Requirements
- R1: After reset `spi_cs_n` is 1, `spi_sck` is 0, `req_ready` is 1 and `done` is 0.
- R2: A request whose offset is at or above DEV_WORDS, whose count is 0, or whose count exceeds DEV_WORDS minus the offset ends with one `done` pulse and `err` = 1, and `spi_cs_n` never goes low.
- R3: Before every read command and every write burst, the block sends status-read opcode 0x05 and shifts in 8 bits. It repeats this, with a standby between attempts, until status bit 0 reads 0, and only then issues the command.
- R4: If status bit 0 is still 1 after MAX_POLL attempts, the request ends with `err` = 2 after exactly MAX_POLL status reads, and `spi_cs_n` is 1.
- R5: The read opcode is 0x03 and the write opcode is 0x02. The address field is twice the word offset, ADDR_W bits, most significant bit first. When ADDR_W is 8 and byte address bit 8 is set, 0x08 is ORed into the opcode.
- R6: A read sends one command, then 16 bits per word. `rd_data` = {second byte received, first byte received}, and there is one `rd_valid` pulse per word.
- R7: A write burst is opcode 0x06 alone, then a standby, then the write command and address, then each word sent as its bits [7:0] followed by bits [15:8]. There is one `wr_take` pulse per word, and `wr_data` is captured in that cycle.
- R8: When the byte address after a written word is a multiple of PAGE_BYTES and words remain, the burst is closed with a standby and restarted at R3. No burst crosses a page.
- R9: SPI mode 0. `spi_sck` idles low, toggles only while `spi_cs_n` is 0, and is 0 whenever `spi_cs_n` changes. `spi_mosi` changes only while `spi_sck` is low.
- R10: A standby holds `spi_cs_n` high for at least SETTLE cycles before driving it low again.
- R11: Each accepted request yields exactly one single-cycle `done` pulse, with `err` = 0 on success. `req_ready` is 0 from acceptance until `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while req_ready is 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | clog2(DEV_WORDS)+1 | Starting word offset |
| req_count | input | clog2(DEV_WORDS)+1 | Number of words |
| req_ready | output | 1 | Idle and able to accept a request |
| wr_data | input | 16 | Next word to write, captured on wr_take |
| wr_take | output | 1 | Write word consumed this cycle |
| rd_data | output | 16 | Received word |
| rd_valid | output | 1 | rd_data holds a new word |
| done | output | 1 | Request finished (one cycle) |
| err | output | 2 | 0 ok, 1 out of range, 2 device never ready |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Data to the device |
| spi_miso | input | 1 | Data from the device |

## Verification
On every cycle, the embedded properties watch the wire discipline of mode 0: the clock stays quiet outside chip select, chip select moves only with the clock low, and MOSI holds while the clock is high. They also check the minimum standby width, the bound on polling attempts, the silence of the bus on rejected requests, and the single `done` pulse. What only the directed scenarios can show is the content on the wire: the opcodes (with the A8 bit), the doubled byte address, byte order in both directions, the count of status reads against a device model that stays busy, and the split of a page-crossing write into two enabled bursts.

// File: rtl/sprom_pkg.sv
package sprom_pkg;
   typedef enum logic [1:0] {
      SP_OK       = 2'd0,
      SP_RANGE    = 2'd1,
      SP_NOTREADY = 2'd2
   } sp_err_e;

   typedef enum logic [3:0] {
      S_IDLE, S_REJ, S_POLL_OP, S_POLL_RX, S_STBY,
      S_WREN, S_CMD, S_ADDR, S_DATA, S_FINISH
   } sp_state_e;

   localparam logic [7:0] OP_RDSR   = 8'h05;
   localparam logic [7:0] OP_WREN   = 8'h06;
   localparam logic [7:0] OP_READ   = 8'h03;
   localparam logic [7:0] OP_WRITE  = 8'h02;
   localparam logic [7:0] OP_HIADDR = 8'h08;
endpackage

// File: rtl/sprom_bit_engine.sv
module sprom_bit_engine #(
   parameter int DIV = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic [4:0]  nbits,
   input  logic [15:0] tx,
   input  logic        miso,
   output logic        busy,
   output logic        done,
   output logic [15:0] rx,
   output logic        sck,
   output logic        mosi
);
   localparam int TW = (DIV < 2) ? 1 : $clog2(DIV);

   logic [15:0] sh;
   logic [4:0]  cnt;
   logic [TW-1:0] tmr;

   assign mosi = sh[15];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '0;
         cnt  <= '0;
         tmr  <= '0;
         busy <= 1'b0;
         done <= 1'b0;
         rx   <= '0;
         sck  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               sh   <= tx << (5'd16 - nbits);
               cnt  <= nbits;
               rx   <= '0;
               tmr  <= '0;
               busy <= 1'b1;
               sck  <= 1'b0;
            end
         end else if (tmr == TW'(DIV - 1)) begin
            tmr <= '0;
            if (!sck) begin
               sck <= 1'b1;
               rx  <= {rx[14:0], miso};
            end else begin
               sck <= 1'b0;
               sh  <= {sh[14:0], 1'b0};
               cnt <= cnt - 5'd1;
               if (cnt == 5'd1) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end
            end
         end else begin
            tmr <= tmr + TW'(1);
         end
      end
   end

   // R9: data may only move while the clock is low
   p_mosi_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sck && $past(sck)) |-> $stable(mosi));

   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !sck));
endmodule

// File: rtl/sprom_req_check.sv
module sprom_req_check #(
   parameter int DEV_WORDS = 256,
   parameter int W         = 9
) (
   input  logic [W-1:0] offset,
   input  logic [W-1:0] count,
   output logic         bad
);
   localparam logic [W:0] SIZE = (W+1)'(DEV_WORDS);

   logic [W:0] room;

   always_comb begin
      room = SIZE - {1'b0, offset};
      bad  = ({1'b0, offset} >= SIZE) || (count == '0) || ({1'b0, count} > room);
   end
endmodule

// File: rtl/sprom_cmd_fmt.sv
module sprom_cmd_fmt #(
   parameter int ADDR_W = 8,
   parameter int OFF_W  = 9
) (
   input  logic [OFF_W-1:0] woff,
   input  logic             is_write,
   output logic [15:0]      opc,
   output logic [15:0]      addr
);
   import sprom_pkg::*;

   logic [7:0] base;
   assign base = is_write ? OP_WRITE : OP_READ;

   generate
      if (ADDR_W == 8) begin : g_addr8
         logic [8:0] bya;
         assign bya  = 9'({woff, 1'b0});
         assign opc  = {8'h00, base | (bya[8] ? OP_HIADDR : 8'h00)};
         assign addr = {8'h00, bya[7:0]};
      end else begin : g_addr16
         logic [15:0] bya;
         assign bya  = 16'({woff, 1'b0});
         assign opc  = {8'h00, base};
         assign addr = bya;
      end
   endgenerate
endmodule

// File: rtl/sprom_word_master.sv
module sprom_word_master #(
   parameter int OPC_W      = 8,
   parameter int ADDR_W     = 8,
   parameter int DEV_WORDS  = 256,
   parameter int PAGE_BYTES = 16,
   parameter int SCK_DIV    = 2,
   parameter int SETTLE     = 2,
   parameter int MAX_POLL   = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   input  logic                        req_write,
   input  logic [$clog2(DEV_WORDS):0]  req_offset,
   input  logic [$clog2(DEV_WORDS):0]  req_count,
   output logic                        req_ready,
   input  logic [15:0]                 wr_data,
   output logic                        wr_take,
   output logic [15:0]                 rd_data,
   output logic                        rd_valid,
   output logic                        done,
   output logic [1:0]                  err,
   output logic                        spi_cs_n,
   output logic                        spi_sck,
   output logic                        spi_mosi,
   input  logic                        spi_miso
);
   import sprom_pkg::*;

   localparam int OFF_W      = $clog2(DEV_WORDS) + 1;
   localparam int PAGE_WORDS = PAGE_BYTES / 2;
   localparam int ST_W       = $clog2(SETTLE + 1);
   localparam int TR_W       = $clog2(MAX_POLL + 1);
   localparam logic [OFF_W-1:0] PG_MASK = OFF_W'(PAGE_WORDS - 1);

   // elaboration-time parameter checks
   if (ADDR_W != 8 && ADDR_W != 16) begin : g_bad_addr
      $error("ADDR_W must be 8 or 16");
   end
   if (OPC_W < 8 || OPC_W > 16) begin : g_bad_opc
      $error("OPC_W must lie in 8..16");
   end
   if (PAGE_BYTES < 2 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two, at least 2");
   end
   if (DEV_WORDS < 2 || DEV_WORDS * 2 > ((ADDR_W == 8) ? 512 : 65536)) begin : g_bad_size
      $error("DEV_WORDS does not fit the address width");
   end
   if (SETTLE < 1 || SETTLE > 255 || SCK_DIV < 1 || MAX_POLL < 1) begin : g_bad_time
      $error("SETTLE, SCK_DIV and MAX_POLL out of range");
   end

   sp_state_e         st, sb_next;
   sp_err_e           err_q;
   logic              wr_mode, issued, sb_low, done_q, rd_valid_q, wr_take_q;
   logic [OFF_W-1:0]  woff, woff_nx;
   logic [OFF_W-1:0]  left;
   logic [TR_W-1:0]   tries;
   logic [ST_W-1:0]   stime;
   logic [15:0]       rd_data_q;
   logic              req_bad, pg_edge;

   logic              eng_go, eng_busy, eng_done;
   logic [4:0]        eng_n;
   logic [15:0]       eng_tx, eng_rx;
   logic [15:0]       fmt_opc, fmt_addr;

   sprom_req_check #(.DEV_WORDS(DEV_WORDS), .W(OFF_W)) u_chk (
      .offset(req_offset), .count(req_count), .bad(req_bad));

   sprom_cmd_fmt #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_fmt (
      .woff(woff), .is_write(wr_mode), .opc(fmt_opc), .addr(fmt_addr));

   sprom_bit_engine #(.DIV(SCK_DIV)) u_eng (
      .clk(clk), .rst_n(rst_n), .start(eng_go), .nbits(eng_n), .tx(eng_tx),
      .miso(spi_miso), .busy(eng_busy), .done(eng_done), .rx(eng_rx),
      .sck(spi_sck), .mosi(spi_mosi));

   assign woff_nx = woff + OFF_W'(1);
   assign pg_edge = (woff_nx & PG_MASK) == '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= S_IDLE;
         sb_next    <= S_IDLE;
         err_q      <= SP_OK;
         wr_mode    <= 1'b0;
         issued     <= 1'b0;
         sb_low     <= 1'b0;
         done_q     <= 1'b0;
         rd_valid_q <= 1'b0;
         wr_take_q  <= 1'b0;
         woff       <= '0;
         left       <= '0;
         tries      <= '0;
         stime      <= '0;
         rd_data_q  <= '0;
         spi_cs_n   <= 1'b1;
         eng_go     <= 1'b0;
         eng_n      <= '0;
         eng_tx     <= '0;
      end else begin
         eng_go     <= 1'b0;
         done_q     <= 1'b0;
         rd_valid_q <= 1'b0;
         wr_take_q  <= 1'b0;
         case (st)
            S_IDLE: begin
               spi_cs_n <= 1'b1;
               issued   <= 1'b0;
               if (req_valid) begin
                  wr_mode <= req_write;
                  woff    <= req_offset;
                  left    <= req_count;
                  tries   <= '0;
                  if (req_bad) begin
                     err_q <= SP_RANGE;
                     st    <= S_REJ;
                  end else begin
                     err_q    <= SP_OK;
                     spi_cs_n <= 1'b0;
                     st       <= S_POLL_OP;
                  end
               end
            end
            S_REJ: begin
               done_q <= 1'b1;
               st     <= S_IDLE;
            end
            S_POLL_OP: begin
               if (!issued) begin
                  eng_go <= 1'b1; eng_n <= 5'(OPC_W); eng_tx <= {8'h00, OP_RDSR};
                  issued <= 1'b1;
               end else if (eng_done) begin
                  issued <= 1'b0;
                  st     <= S_POLL_RX;
               end
            end
            S_POLL_RX: begin
               if (!issued) begin
                  eng_go <= 1'b1; eng_n <= 5'd8; eng_tx <= '0;
                  issued <= 1'b1;
               end else if (eng_done) begin
                  issued <= 1'b0;
                  if (!eng_rx[0]) begin
                     st      <= S_STBY;
                     sb_next <= wr_mode ? S_WREN : S_CMD;
                  end else if (tries == TR_W'(MAX_POLL - 1)) begin
                     err_q <= SP_NOTREADY;
                     st    <= S_FINISH;
                  end else begin
                     tries   <= tries + TR_W'(1);
                     st      <= S_STBY;
                     sb_next <= S_POLL_OP;
                  end
               end
            end
            S_STBY: begin
               if (!sb_low) begin
                  spi_cs_n <= 1'b1;
                  if (stime == ST_W'(SETTLE)) begin
                     stime    <= '0;
                     sb_low   <= 1'b1;
                     spi_cs_n <= 1'b0;
                  end else begin
                     stime <= stime + ST_W'(1);
                  end
               end else if (stime == ST_W'(SETTLE - 1)) begin
                  stime  <= '0;
                  sb_low <= 1'b0;
                  st     <= sb_next;
               end else begin
                  stime <= stime + ST_W'(1);
               end
            end
            S_WREN: begin
               if (!issued) begin
                  eng_go <= 1'b1; eng_n <= 5'(OPC_W); eng_tx <= {8'h00, OP_WREN};
                  issued <= 1'b1;
               end else if (eng_done) begin
                  issued  <= 1'b0;
                  st      <= S_STBY;
                  sb_next <= S_CMD;
               end
            end
            S_CMD: begin
               if (!issued) begin
                  eng_go <= 1'b1; eng_n <= 5'(OPC_W); eng_tx <= fmt_opc;
                  issued <= 1'b1;
               end else if (eng_done) begin
                  issued <= 1'b0;
                  st     <= S_ADDR;
               end
            end
            S_ADDR: begin
               if (!issued) begin
                  eng_go <= 1'b1; eng_n <= 5'(ADDR_W); eng_tx <= fmt_addr;
                  issued <= 1'b1;
               end else if (eng_done) begin
                  issued <= 1'b0;
                  st     <= S_DATA;
               end
            end
            S_DATA: begin
               if (!issued) begin
                  eng_go <= 1'b1;
                  eng_n  <= 5'd16;
                  issued <= 1'b1;
                  if (wr_mode) begin
                     wr_take_q <= 1'b1;
                     eng_tx    <= {wr_data[7:0], wr_data[15:8]};
                  end else begin
                     eng_tx <= '0;
                  end
               end else if (eng_done) begin
                  issued <= 1'b0;
                  if (!wr_mode) begin
                     rd_valid_q <= 1'b1;
                     rd_data_q  <= {eng_rx[7:0], eng_rx[15:8]};
                  end
                  woff <= woff_nx;
                  left <= left - OFF_W'(1);
                  if (left == OFF_W'(1)) begin
                     st <= S_FINISH;
                  end else if (wr_mode && pg_edge) begin
                     tries   <= '0;
                     st      <= S_STBY;
                     sb_next <= S_POLL_OP;
                  end
               end
            end
            S_FINISH: begin
               spi_cs_n <= 1'b1;
               done_q   <= 1'b1;
               st       <= S_IDLE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign req_ready = (st == S_IDLE);
   assign done      = done_q;
   assign err       = err_q;
   assign rd_valid  = rd_valid_q;
   assign rd_data   = rd_data_q;
   assign wr_take   = wr_take_q;

   // run length of chip-select high, used by the standby check
   logic [7:0] hi_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        hi_cnt <= '0;
      else if (spi_cs_n) hi_cnt <= (hi_cnt == 8'hFF) ? hi_cnt : hi_cnt + 8'd1;
      else               hi_cnt <= '0;
   end

   p_sck_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sck);
   p_cs_move_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(spi_cs_n) |-> !spi_sck);
   p_stby_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(spi_cs_n) && st == S_STBY) |-> hi_cnt >= 8'(SETTLE));
   p_poll_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tries < TR_W'(MAX_POLL));
   p_reject_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_REJ) |-> spi_cs_n);
   p_take_in_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_take |-> (wr_mode && st == S_DATA));
   p_single_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_pulses_apart_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, rd_valid, wr_take}));
endmodule

// File: tb/sim_sprom_word_master.sv
module sim_sprom_word_master;
   localparam int DEV_WORDS = 256;
   localparam int PAGE_B    = 16;
   localparam int SETTLE    = 2;
   localparam int MAX_POLL  = 8;
   localparam int BUSY_POLL = 2;
   localparam int OW        = $clog2(DEV_WORDS) + 1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [OW-1:0] req_offset = '0, req_count = '0;
   logic req_ready, wr_take, rd_valid, done;
   logic [15:0] wr_data, rd_data;
   logic [1:0] err;
   logic cs_n, sck, mosi;
   logic miso = 1'b0;

   always #4 clk = ~clk;

   sprom_word_master #(.DEV_WORDS(DEV_WORDS), .PAGE_BYTES(PAGE_B),
      .SETTLE(SETTLE), .MAX_POLL(MAX_POLL)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_offset(req_offset), .req_count(req_count), .req_ready(req_ready),
      .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
      .done(done), .err(err), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
      .spi_miso(miso));

   int checks = 0, fails = 0;
   bit finished = 1'b0;

   // ---------------- device model ----------------
   logic [7:0] mem [0:511];
   logic [7:0] inb, obyte, opc;
   logic [8:0] addr;
   int nb, bi, wbytes, wpage, busy_left = 0;
   bit wel = 1'b0, stuck = 1'b0;
   int rdsr_cnt = 0, wren_cnt = 0, burst_cnt = 0, proto_err = 0, cs_falls = 0;
   logic [7:0] last_rw_opc = 8'h00;

   initial for (int i = 0; i < 512; i++) mem[i] = 8'(i * 7 + 3);

   function automatic bit is_rd(input logic [7:0] o); return (o & 8'hF7) == 8'h03; endfunction
   function automatic bit is_wr(input logic [7:0] o); return (o & 8'hF7) == 8'h02; endfunction

   always @(negedge cs_n) begin
      nb = 0; bi = 0; obyte = 8'h00; wbytes = 0; cs_falls++;
   end
   always @(posedge cs_n) begin
      if (bi > 0 && is_wr(opc) && wbytes > 0) begin
         busy_left = BUSY_POLL; wel = 1'b0; burst_cnt++;
      end
   end
   always @(posedge sck) if (!cs_n) begin
      inb = {inb[6:0], mosi};
      nb++;
      if (nb == 8) begin
         nb = 0;
         if (bi == 0) begin
            opc = inb;
            if (inb == 8'h05) begin
               rdsr_cnt++;
               obyte = {7'b0, stuck || busy_left != 0};
               if (busy_left > 0) busy_left--;
            end else if (inb == 8'h06) begin
               wel = 1'b1; wren_cnt++;
            end else if (is_rd(inb) || is_wr(inb)) begin
               last_rw_opc = inb;
               if (busy_left != 0 || stuck) proto_err++;
            end
         end else if (bi == 1 && (is_rd(opc) || is_wr(opc))) begin
            addr = {opc[3], inb};
            wpage = int'(addr) / PAGE_B;
            if (is_rd(opc)) begin obyte = mem[addr]; addr = addr + 9'd1; end
         end else if (bi >= 2 && is_rd(opc)) begin
            obyte = mem[addr]; addr = addr + 9'd1;
         end else if (bi >= 2 && is_wr(opc)) begin
            if (!wel) proto_err++;
            if (int'(addr) / PAGE_B != wpage) proto_err++;
            mem[addr] = inb; addr = addr + 9'd1; wbytes++;
         end
         bi++;
      end
   end
   always @(negedge sck) if (!cs_n) begin
      miso = obyte[7]; obyte = {obyte[6:0], 1'b0};
   end

   // ---------------- host side ----------------
   logic [15:0] wr_buf [0:15];
   logic [15:0] rd_buf [0:15];
   int wptr = 0, rcnt = 0, done_cnt = 0;
   assign wr_data = wr_buf[wptr];

   // wire-discipline monitors (R9, R10)
   logic p_sck = 1'b0, p_mosi = 1'b0, p_cs = 1'b1;
   int bad9 = 0, hi_run = 0, min_run = 1000, stby_seen = 0;

   always @(negedge clk) begin
      if (rd_valid) begin rd_buf[rcnt] = rd_data; rcnt++; end
      if (wr_take) wptr++;
      if (done) done_cnt++;
      if (cs_n && sck) bad9++;
      if (sck && p_sck && mosi !== p_mosi) bad9++;
      if (cs_n !== p_cs && sck) bad9++;
      if (cs_n && !req_ready) hi_run++;
      else if (!cs_n && p_cs && hi_run > 0) begin
         stby_seen++;
         if (hi_run < min_run) min_run = hi_run;
         hi_run = 0;
      end else if (!cs_n) hi_run = 0;
      p_sck = sck; p_mosi = mosi; p_cs = cs_n;
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   logic [1:0] last_err;
   int last_done_cycles;

   task automatic run_req(input bit w, input int off, input int cnt);
      int t;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      rcnt = 0; wptr = 0;
      req_valid = 1'b1; req_write = w;
      req_offset = OW'(off); req_count = OW'(cnt);
      @(negedge clk);
      req_valid = 1'b0;
      t = 0;
      while (!done && t < 30000) begin @(negedge clk); t++; end
      last_err = err;
      last_done_cycles = t;
   endtask

   function automatic logic [15:0] word_at(input int k);
      return {mem[2 * k + 1], mem[2 * k]};
   endfunction

   task automatic t_reset;
      check("R1 cs_n", cs_n, 1);
      check("R1 sck", sck, 0);
      check("R1 ready", req_ready, 1);
      check("R1 done", done, 0);
   endtask

   task automatic t_range;
      int f0 = cs_falls, d0 = done_cnt;
      run_req(1'b0, 256, 1); check("R2 offset too big err", last_err, 1);
      run_req(1'b1, 10, 0);  check("R2 zero count err", last_err, 1);
      run_req(1'b0, 255, 2); check("R2 count past end err", last_err, 1);
      @(negedge clk);
      check("R2 no bus activity", cs_falls - f0, 0);
      check("R11 one done per request", done_cnt - d0, 3);
      run_req(1'b0, 255, 1);
      check("R2 last word accepted", last_err, 0);
      check("R6 last word data", rd_buf[0], word_at(255));
   endtask

   task automatic t_write_small;
      int w0 = wren_cnt, b0 = burst_cnt;
      wr_buf[0] = 16'h1234; wr_buf[1] = 16'hABCD; wr_buf[2] = 16'h0F0E;
      run_req(1'b1, 4, 3);
      check("R11 write ok", last_err, 0);
      check("R7 take pulses", wptr, 3);
      check("R7 low byte first", mem[8], 8'h34);
      check("R7 high byte second", mem[9], 8'h12);
      check("R7 last word", word_at(6), 16'h0F0E);
      check("R7 one wren", wren_cnt - w0, 1);
      check("R7 one burst", burst_cnt - b0, 1);
      check("R5 write opcode", last_rw_opc, 8'h02);
   endtask

   task automatic t_read_small;
      int r0 = rdsr_cnt;
      run_req(1'b0, 4, 3);
      check("R11 read ok", last_err, 0);
      check("R6 word count", rcnt, 3);
      check("R6 word0 swapped", rd_buf[0], 16'h1234);
      check("R6 word1", rd_buf[1], 16'hABCD);
      check("R6 word2", rd_buf[2], 16'h0F0E);
      check("R3 polls until ready", rdsr_cnt - r0, BUSY_POLL + 1);
      check("R5 read opcode", last_rw_opc, 8'h03);
   endtask

   task automatic t_page;
      int w0 = wren_cnt, b0 = burst_cnt, r0 = rdsr_cnt;
      for (int i = 0; i < 5; i++) wr_buf[i] = 16'hC000 + 16'(i * 16'h0111);
      run_req(1'b1, 6, 5);
      check("R8 write ok", last_err, 0);
      check("R8 two bursts", burst_cnt - b0, 2);
      check("R8 two wren", wren_cnt - w0, 2);
      check("R8 repoll", rdsr_cnt - r0, 1 + BUSY_POLL + 1);
      check("R8 no page crossing", proto_err, 0);
      for (int i = 0; i < 5; i++)
         check("R8 data", word_at(6 + i), 16'hC000 + 16'(i * 16'h0111));
   endtask

   task automatic t_hiaddr;
      logic [15:0] e [0:3];
      wr_buf[0] = 16'h5AA5; wr_buf[1] = 16'h00FF;
      run_req(1'b1, 130, 2);
      check("R5 A8 write opcode", last_rw_opc, 8'h0A);
      check("R5 A8 write data", mem[260], 8'hA5);
      check("R5 A8 write data hi", word_at(131), 16'h00FF);
      for (int i = 0; i < 4; i++) e[i] = word_at(127 + i);
      run_req(1'b0, 127, 4);
      check("R5 low opcode at 127", last_rw_opc, 8'h03);
      for (int i = 0; i < 4; i++) check("R6 stream over bit 8", rd_buf[i], e[i]);
      run_req(1'b0, 200, 1);
      check("R5 A8 read opcode", last_rw_opc, 8'h0B);
      check("R5 A8 read data", rd_buf[0], word_at(200));
   endtask

   task automatic t_timeout;
      int r0;
      run_req(1'b0, 0, 1);
      r0 = rdsr_cnt;
      stuck = 1'b1;
      run_req(1'b0, 0, 1);
      check("R4 not-ready err", last_err, 2);
      check("R4 attempt count", rdsr_cnt - r0, MAX_POLL);
      check("R4 no data", rcnt, 0);
      check("R4 cs released", cs_n, 1);
      stuck = 1'b0;
      run_req(1'b0, 1, 1);
      check("R4 recovers", last_err, 0);
   endtask

   task automatic summary;
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      for (int i = 0; i < 16; i++) wr_buf[i] = '0;
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_range;
      t_write_small;
      t_read_small;
      t_page;
      t_hiaddr;
      t_timeout;
      check("R9 mode0 wire discipline", bad9, 0);
      check("R10 standby seen", stby_seen > 0, 1);
      check("R10 standby width", min_run >= SETTLE, 1);
      check("R3 protocol errors", proto_err, 0);
      summary;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      summary;
   end
endmodule